// File: doc/BRIEF.md
# Asynchronous DRAM Access Controller

This block turns single requests from a synchronous valid/ready port into the strobe sequences of an asynchronous DRAM with a multiplexed address bus and a byte-wide data path. The 20-bit request address is split into a row half and a column half. The two halves are placed on a 10-bit address bus one after the other. The row is latched by the row strobe and the column by the column strobe. Reads return one byte together with a one-clock valid pulse. Writes always use the early form: the write strobe and the data go out before the column strobe falls, so the memory never drives its data pins during a write.

Every DRAM timing minimum is a parameter counted in clock cycles. The controller holds the row strobe low for at least the active minimum and keeps both strobes high for their precharge minimums. A read is sampled only once the longest of the four access delays has passed. A level request, `sref_req`, takes the memory into self-refresh with the column strobe leading the row strobe. It brings the memory back out with the column strobe held past the row strobe's rise, then waits out a recovery interval. The data bus is split at the pad boundary into output, output-enable and input.

Top module: `dram_async_ctrl`

## Requirements
- R1: While reset is asserted, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are 1, `dram_dq_oe` is 0 and `rd_valid` is 0. After reset is released, `req_ready` is 1 with no request pending.
- R2: In a normal cycle `dram_addr` holds `req_addr[19:10]` when `dram_ras_n` falls, and holds `req_addr[9:0]` when `dram_cas_n` falls.
- R3: In a read (`req_write`=0), `dram_we_n` stays 1 for the whole time `dram_ras_n` is low, and `dram_oe_n` is driven low with the column strobe.
- R4: Read data is sampled no earlier than the largest of the RAS, CAS, column-address and OE access counts. It appears on `rd_data` with `rd_valid` high for exactly one clock, once per read.
- R5: In a write (`req_write`=1), `dram_we_n` is 0, `dram_dq_oe` is 1 and `dram_dq_out` equals the request data in the clock before `dram_cas_n` falls, and they are still in that state when it falls.
- R6: During a write, `dram_oe_n` stays 1. Every normal cycle ends with `dram_cas_n` and `dram_ras_n` rising in the same clock.
- R7: `dram_ras_n` stays low for at least `T_RAS` clocks in a normal cycle, and for at least `T_RASS` clocks in self-refresh.
- R8: `dram_ras_n` stays high for at least `T_RP` clocks before any fall, and `dram_cas_n` stays high for at least `T_CP` clocks before any fall.
- R9: Self-refresh entry drives `dram_cas_n` low at least `T_CSR` clocks before `dram_ras_n` falls. `dram_ras_n` then stays low while `sref_req` is held.
- R10: On self-refresh exit, `dram_cas_n` stays low for at least `T_CHS` clocks after `dram_ras_n` rises. No new cycle starts within `T_CHS+T_RPS` clocks of the rise.
- R11: `req_ready` is 0 from the clock after a request is accepted until every precharge interval has elapsed. `sref_req` takes priority over `req_valid` when both are high in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this clock if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address, row in upper half, column in lower half |
| req_wdata | input | 8 | Write data |
| sref_req | input | 1 | Level request to enter and stay in self-refresh |
| rd_valid | output | 1 | One-clock pulse with read data |
| rd_data | output | 8 | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data toward the memory |
| dram_dq_oe | output | 1 | Data pad driver enable |
| dram_dq_in | input | 8 | Data from the memory |

## Verification
A sequencer that leaves a state early or late shows up at the pins within one cycle. It appears as a strobe edge that breaks a measured low or high count, or as an address that does not match the row or column half of the request. A short read-access count shows only one clock later, as a wrong byte on `rd_data`, because the bench memory returns inverted data until all of its access counts are met. A lost or stuck write-select state shows up at the next read of the same address. A broken self-refresh exit shows as a column strobe that rises together with the row strobe, or as a new row strobe too soon after the exit.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_RASF,
    ST_COL,
    ST_CASL,
    ST_HOLD,
    ST_PRE,
    ST_SR_CAS,
    ST_SR_HOLD,
    ST_SR_CHS,
    ST_SR_PRE
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_interval_timer.sv
module dram_interval_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int PIN_AW = 10,
  parameter int DW     = 8,
  parameter int CW     = 8,
  parameter int T_ASR  = 1,
  parameter int T_RAH  = 1,
  parameter int T_ASC  = 1,
  parameter int T_RAC  = 6,
  parameter int T_CAC  = 3,
  parameter int T_CAA  = 4,
  parameter int T_OEA  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RAS  = 8,
  parameter int T_RP   = 4,
  parameter int T_CP   = 2,
  parameter int T_CSR  = 2,
  parameter int T_RASS = 10,
  parameter int T_CHS  = 2,
  parameter int T_RPS  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [2*PIN_AW-1:0] req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic                sref_req,
  input  logic                phase_done,
  input  logic                ras_done,
  input  logic [DW-1:0]       dq_in,
  output seq_state_e          state_d,
  output logic                req_ready,
  output logic [2*PIN_AW-1:0] addr_nxt,
  output logic                write_nxt,
  output logic [DW-1:0]       wdata_q,
  output logic                phase_load,
  output logic [CW-1:0]       phase_val,
  output logic                ras_load,
  output logic [CW-1:0]       ras_val,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data
);

  // read wait = longest access count seen from the column strobe edge
  localparam int T_ACC = imax(imax(T_CAC, T_OEA),
                              imax(imax(T_CAA - T_ASC, T_RAC - T_RAH - T_ASC), 1));
  localparam int T_PRE = imax(T_RP, T_CP);

  localparam logic [CW-1:0] L_ASR  = CW'(T_ASR - 1);
  localparam logic [CW-1:0] L_RAH  = CW'(T_RAH - 1);
  localparam logic [CW-1:0] L_ASC  = CW'(T_ASC - 1);
  localparam logic [CW-1:0] L_ACC  = CW'(T_ACC - 1);
  localparam logic [CW-1:0] L_CAS  = CW'(T_CAS - 1);
  localparam logic [CW-1:0] L_PRE  = CW'(T_PRE - 1);
  localparam logic [CW-1:0] L_CSR  = CW'(T_CSR - 1);
  localparam logic [CW-1:0] L_CHS  = CW'(T_CHS - 1);
  localparam logic [CW-1:0] L_RPS  = CW'(T_RPS - 1);
  localparam logic [CW-1:0] L_RAS  = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RASS = CW'(T_RASS - 1);

  seq_state_e          state_q;
  logic [2*PIN_AW-1:0] addr_q;
  logic                write_q;
  logic [DW-1:0]       wdata_r;
  logic [DW-1:0]       rdata_q;
  logic                rvalid_q;
  logic                accept;
  logic                capture;

  assign req_ready = (state_q == ST_IDLE) && !sref_req;
  assign accept    = req_ready && req_valid;
  assign capture   = (state_q == ST_CASL) && phase_done && !write_q;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (sref_req) state_d = ST_SR_CAS;
                  else if (req_valid) state_d = ST_ROW;
      ST_ROW:     if (phase_done) state_d = ST_RASF;
      ST_RASF:    if (phase_done) state_d = ST_COL;
      ST_COL:     if (phase_done) state_d = ST_CASL;
      ST_CASL:    if (phase_done) state_d = ST_HOLD;
      ST_HOLD:    if (ras_done) state_d = ST_PRE;
      ST_PRE:     if (phase_done) state_d = ST_IDLE;
      ST_SR_CAS:  if (phase_done) state_d = ST_SR_HOLD;
      ST_SR_HOLD: if (ras_done && !sref_req) state_d = ST_SR_CHS;
      ST_SR_CHS:  if (phase_done) state_d = ST_SR_PRE;
      ST_SR_PRE:  if (phase_done) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // interval loads on state entry
  always_comb begin
    phase_load = (state_d != state_q);
    ras_load   = phase_load && ((state_d == ST_RASF) || (state_d == ST_SR_HOLD));
    ras_val    = (state_d == ST_SR_HOLD) ? L_RASS : L_RAS;
    unique case (state_d)
      ST_ROW:    phase_val = L_ASR;
      ST_RASF:   phase_val = L_RAH;
      ST_COL:    phase_val = L_ASC;
      ST_CASL:   phase_val = write_q ? L_CAS : L_ACC;
      ST_PRE:    phase_val = L_PRE;
      ST_SR_CAS: phase_val = L_CSR;
      ST_SR_CHS: phase_val = L_CHS;
      ST_SR_PRE: phase_val = L_RPS;
      default:   phase_val = '0;
    endcase
  end

  assign addr_nxt  = accept ? req_addr : addr_q;
  assign write_nxt = accept ? req_write : write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      write_q  <= 1'b0;
      wdata_r  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= capture;
      if (accept) begin
        addr_q  <= req_addr;
        write_q <= req_write;
        wdata_r <= req_wdata;
      end
      if (capture)
        rdata_q <= dq_in;
    end
  end

  assign wdata_q  = wdata_r;
  assign rd_valid = rvalid_q;
  assign rd_data  = rdata_q;

endmodule

// File: rtl/dram_pin_regs.sv
module dram_pin_regs
  import dram_ctrl_pkg::*;
#(
  parameter int PIN_AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  seq_state_e          state_d,
  input  logic [2*PIN_AW-1:0] addr_nxt,
  input  logic                write_nxt,
  output logic                ras_n,
  output logic                cas_n,
  output logic                we_n,
  output logic                oe_n,
  output logic                dq_oe,
  output logic [PIN_AW-1:0]   addr
);

  logic            ras_lo, cas_lo, col_phase, row_phase, addr_en;
  logic [PIN_AW-1:0] addr_d;

  always_comb begin
    ras_lo    = (state_d == ST_RASF) || (state_d == ST_COL) || (state_d == ST_CASL) ||
                (state_d == ST_HOLD) || (state_d == ST_SR_HOLD);
    cas_lo    = (state_d == ST_CASL) || (state_d == ST_HOLD) || (state_d == ST_SR_CAS) ||
                (state_d == ST_SR_HOLD) || (state_d == ST_SR_CHS);
    col_phase = (state_d == ST_COL) || (state_d == ST_CASL) || (state_d == ST_HOLD);
    row_phase = (state_d == ST_ROW) || (state_d == ST_RASF);
    addr_en   = col_phase || row_phase;
    addr_d    = row_phase ? addr_nxt[2*PIN_AW-1:PIN_AW] : addr_nxt[PIN_AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
      addr  <= '0;
    end else begin
      ras_n <= !ras_lo;
      cas_n <= !cas_lo;
      we_n  <= !(col_phase && write_nxt);
      dq_oe <= col_phase && write_nxt;
      oe_n  <= !(((state_d == ST_CASL) || (state_d == ST_HOLD)) && !write_nxt);
      if (addr_en)
        addr <= addr_d;
    end
  end

endmodule

// File: rtl/dram_async_ctrl.sv
module dram_async_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int PIN_AW = 10,
  parameter int DW     = 8,
  parameter int CW     = 8,
  parameter int T_ASR  = 1,
  parameter int T_RAH  = 1,
  parameter int T_ASC  = 1,
  parameter int T_RAC  = 6,
  parameter int T_CAC  = 3,
  parameter int T_CAA  = 4,
  parameter int T_OEA  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RAS  = 8,
  parameter int T_RP   = 4,
  parameter int T_CP   = 2,
  parameter int T_CSR  = 2,
  parameter int T_RASS = 10,
  parameter int T_CHS  = 2,
  parameter int T_RPS  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [2*PIN_AW-1:0] req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic                sref_req,
  output logic                rd_valid,
  output logic [DW-1:0]       rd_data,
  output logic                dram_ras_n,
  output logic                dram_cas_n,
  output logic                dram_we_n,
  output logic                dram_oe_n,
  output logic [PIN_AW-1:0]   dram_addr,
  output logic [DW-1:0]       dram_dq_out,
  output logic                dram_dq_oe,
  input  logic [DW-1:0]       dram_dq_in
);

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  seq_state_e          state_d;
  logic [2*PIN_AW-1:0] addr_nxt;
  logic                write_nxt;
  logic                phase_load, ras_load, phase_done, ras_done;
  logic [CW-1:0]       phase_val, ras_val;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dram_seq_fsm #(
    .PIN_AW(PIN_AW), .DW(DW), .CW(CW),
    .T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_RAC(T_RAC),
    .T_CAC(T_CAC), .T_CAA(T_CAA), .T_OEA(T_OEA), .T_CAS(T_CAS),
    .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP), .T_CSR(T_CSR),
    .T_RASS(T_RASS), .T_CHS(T_CHS), .T_RPS(T_RPS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .sref_req   (sref_req),
    .phase_done (phase_done),
    .ras_done   (ras_done),
    .dq_in      (dram_dq_in),
    .state_d    (state_d),
    .req_ready  (req_ready),
    .addr_nxt   (addr_nxt),
    .write_nxt  (write_nxt),
    .wdata_q    (dram_dq_out),
    .phase_load (phase_load),
    .phase_val  (phase_val),
    .ras_load   (ras_load),
    .ras_val    (ras_val),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  dram_interval_timer #(.CW(CW)) u_phase_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (phase_load),
    .load_val (phase_val),
    .done     (phase_done)
  );

  dram_interval_timer #(.CW(CW)) u_ras_tmr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (ras_load),
    .load_val (ras_val),
    .done     (ras_done)
  );

  dram_pin_regs #(.PIN_AW(PIN_AW)) u_pins (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .state_d   (state_d),
    .addr_nxt  (addr_nxt),
    .write_nxt (write_nxt),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .dq_oe     (dram_dq_oe),
    .addr      (dram_addr)
  );

endmodule

// File: rtl/dram_async_ctrl_chk.sv
module dram_async_ctrl_chk #(
  parameter int T_RAS = 8,
  parameter int T_CP  = 2,
  parameter int T_CSR = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rd_valid,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n,
  input logic dram_oe_n,
  input logic dram_dq_oe
);

  logic [15:0] ras_lo_cnt, cas_lo_cnt, cas_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo_cnt <= '0;
      cas_lo_cnt <= '0;
      cas_hi_cnt <= 16'd1000;
    end else begin
      ras_lo_cnt <= dram_ras_n ? '0 : ((ras_lo_cnt == 16'hFFFF) ? ras_lo_cnt : ras_lo_cnt + 1'b1);
      cas_lo_cnt <= dram_cas_n ? '0 : ((cas_lo_cnt == 16'hFFFF) ? cas_lo_cnt : cas_lo_cnt + 1'b1);
      cas_hi_cnt <= !dram_cas_n ? '0 : ((cas_hi_cnt == 16'hFFFF) ? cas_hi_cnt : cas_hi_cnt + 1'b1);
    end
  end

  p_idle_pins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dram_ras_n && dram_cas_n && dram_we_n));

  p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_early_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_dq_oe) && !$past(dram_we_n)));

  p_write_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> dram_oe_n);

  p_ras_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (ras_lo_cnt >= 16'(T_RAS)));

  p_cas_pre_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (cas_hi_cnt >= 16'(T_CP)));

  p_sref_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> (cas_lo_cnt >= 16'(T_CSR)));

endmodule

bind dram_async_ctrl dram_async_ctrl_chk #(
  .T_RAS(T_RAS), .T_CP(T_CP), .T_CSR(T_CSR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_oe_n  (dram_oe_n),
  .dram_dq_oe (dram_dq_oe)
);

// File: tb/tb_dram_async_ctrl.sv
module tb_dram_async_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int T_RAC = 6, T_CAC = 3, T_OEA = 2;
  localparam int T_RAS = 8, T_RP = 4, T_CP = 2;
  localparam int T_CSR = 2, T_RASS = 10, T_CHS = 2, T_RPS = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write, sref_req;
  logic [19:0] req_addr;
  logic [7:0]  req_wdata;
  logic rd_valid;
  logic [7:0] rd_data;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [9:0] dram_addr;
  logic [7:0] dq_out, dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .sref_req(sref_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(dram_addr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe),
    .dram_dq_in(dq_in)
  );

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input logic [19:0] a);
    return a[7:0] ^ a[19:12] ^ 8'h5a;
  endfunction

  // bench memory and shadow of expected contents
  logic [7:0] mem    [int];
  logic [7:0] shadow [int];

  function automatic logic [7:0] shadow_rd(input logic [19:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
  endfunction

  // current request as seen by the monitor
  logic        cur_write;
  logic [19:0] cur_addr;
  logic [7:0]  cur_wdata;
  bit          mon_on = 0;

  int ras_lo = 0, ras_hi = 1000, cas_lo = 0, cas_hi = 1000, oe_lo = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1, p_dq_oe = 0, p_ready = 1;
  logic [7:0] p_dq = '0;
  logic [9:0] row_m = '0;
  logic [7:0] model_val = '0;
  bit sref_cyc = 0, last_sref = 0, bad_we = 0, bad_oe = 0;

  // memory answers inverted data until every access count is met
  assign dq_in = ((ras_lo >= T_RAC) && (cas_lo >= T_CAC) && (oe_lo >= T_OEA))
                 ? model_val : ~model_val;

  always @(negedge clk) begin
    if (mon_on) begin
      if (p_ras && !ras_n) begin
        chk(ras_hi >= (last_sref ? (T_CHS + T_RPS) : T_RP), "R8/R10",
            "row strobe high time before fall", ras_hi, last_sref ? T_CHS + T_RPS : T_RP);
        if (!cas_n) begin
          sref_cyc = 1;
          chk(cas_lo >= T_CSR, "R9", "column lead before self-refresh", cas_lo, T_CSR);
        end else begin
          sref_cyc = 0;
          bad_we = 0;
          bad_oe = 0;
          row_m = dram_addr;
          chk(dram_addr == cur_addr[19:10], "R2", "row address", dram_addr, cur_addr[19:10]);
        end
      end
      if (p_cas && !cas_n && !ras_n) begin
        chk(cas_hi >= T_CP, "R8", "column strobe high time", cas_hi, T_CP);
        chk(dram_addr == cur_addr[9:0], "R2", "column address", dram_addr, cur_addr[9:0]);
        if (cur_write) begin
          chk(!p_we && p_dq_oe && (p_dq == cur_wdata) && !we_n && dq_oe,
              "R5", "early write setup", {p_we, p_dq_oe}, 2'b01);
          chk(dq_out == cur_wdata, "R5", "write data at strobe", dq_out, cur_wdata);
          mem[int'({row_m, dram_addr})] = dq_out;
        end else begin
          model_val = mem.exists(int'({row_m, dram_addr})) ?
                      mem[int'({row_m, dram_addr})] : init_val({row_m, dram_addr});
        end
      end
      if (!ras_n && !sref_cyc) begin
        if (!cur_write && !we_n) bad_we = 1;
        if (cur_write && !oe_n) bad_oe = 1;
      end
      if (!p_ras && ras_n) begin
        chk(ras_lo >= (sref_cyc ? T_RASS : T_RAS), "R7", "row strobe low time",
            ras_lo, sref_cyc ? T_RASS : T_RAS);
        if (!sref_cyc) begin
          chk(!p_cas && cas_n, "R6", "strobes rise together", cas_n, 1);
          if (cur_write) chk(!bad_oe, "R6", "output enable during write", bad_oe, 0);
          else           chk(!bad_we, "R3", "write enable during read", bad_we, 0);
        end
        last_sref = sref_cyc;
      end
      if (!p_cas && cas_n && p_ras && ras_n && sref_cyc)
        chk(ras_hi >= T_CHS, "R10", "column hold after row rise", ras_hi, T_CHS);
      if (!p_ready && req_ready)
        chk(ras_hi >= (last_sref ? T_RPS : T_RP) && cas_hi >= T_CP, "R11",
            "ready before precharge end", ras_hi, last_sref ? T_RPS : T_RP);
    end
    ras_lo = ras_n ? 0 : ras_lo + 1;
    ras_hi = ras_n ? ras_hi + 1 : 0;
    cas_lo = cas_n ? 0 : cas_lo + 1;
    cas_hi = cas_n ? cas_hi + 1 : 0;
    oe_lo  = oe_n  ? 0 : oe_lo + 1;
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_dq_oe = dq_oe; p_dq = dq_out;
    p_ready = req_ready;
  end

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    wait_ready();
    cur_write = 1; cur_addr = a; cur_wdata = d;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    shadow[int'(a)] = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R11", "ready low after accept", req_ready, 0);
  endtask

  task automatic do_read(input logic [19:0] a);
    int n = 0;
    @(negedge clk);
    wait_ready();
    cur_write = 0; cur_addr = a; cur_wdata = '0;
    req_valid = 1; req_write = 0; req_addr = a; req_wdata = $urandom;
    @(negedge clk);
    req_valid = 0;
    while (!rd_valid && n < 100) begin @(negedge clk); n++; end
    chk(rd_valid, "R4", "read valid arrives", rd_valid, 1);
    chk(rd_data == shadow_rd(a), "R4", "read data", rd_data, shadow_rd(a));
    @(negedge clk);
    chk(!rd_valid, "R4", "valid is one clock", rd_valid, 0);
  endtask

  task automatic do_sref(input int hold);
    @(negedge clk);
    wait_ready();
    sref_req = 1;
    repeat (hold) @(negedge clk);
    if (hold > T_CSR + 2)
      chk(!ras_n, "R9", "row strobe low while request held", ras_n, 0);
    sref_req = 0;
    repeat (T_RASS + T_CHS + T_RPS + 4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [19:0] pool [16];
    void'($urandom(32'd20240611));
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; sref_req = 0;
    cur_write = 0; cur_addr = '0; cur_wdata = '0;
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1", "strobes high in reset",
        {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !rd_valid, "R1", "bus released in reset", {dq_oe, rd_valid}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R1", "ready after reset", req_ready, 1);
    mon_on = 1;

    // directed corners
    do_write(20'hFFFFF, 8'hA5);
    do_read(20'hFFFFF);
    do_write(20'h00000, 8'h3C);
    do_read(20'h00000);
    do_read(20'h12345);
    do_write(20'h003FF, 8'h00);
    do_read(20'h003FF);
    do_sref(1);
    do_read(20'hFFFFF);
    do_sref(30);

    // self-refresh wins over a simultaneous request
    @(negedge clk);
    wait_ready();
    cur_write = 0; cur_addr = 20'h0ABCD;
    req_valid = 1; req_write = 0; req_addr = 20'h0ABCD; sref_req = 1;
    while (cas_n && ras_n) @(negedge clk);
    chk(!cas_n && ras_n, "R11", "self-refresh taken first", cas_n, 0);
    repeat (3) @(negedge clk);
    sref_req = 0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rd_valid) @(negedge clk);
    chk(rd_data == shadow_rd(20'h0ABCD), "R4", "read after priority", rd_data,
        shadow_rd(20'h0ABCD));
    repeat (T_RP + 4) @(negedge clk);

    // random traffic
    foreach (pool[i]) pool[i] = 20'($urandom);
    for (int k = 0; k < 120; k++) begin
      int sel = $urandom_range(15);
      int kind = $urandom_range(9);
      if (kind < 4)       do_write(pool[sel], 8'($urandom));
      else if (kind < 9)  do_read(pool[sel]);
      else                do_sref($urandom_range(1, 20));
    end
    repeat (20) @(negedge clk);

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule